// File: doc/BRIEF.md
# General-Purpose Pin Port Register Block

This block is the register file of a sixteen-pin general-purpose I/O port. It sits on a simple 32-bit register bus with a word address, a write strobe, a read strobe, write data and combinational read data. For each pin it stores a direction/function mode, a drive type, a drive speed, a pull selection and a 4-bit alternate-function select. It drives these settings straight to the pad ring and to the function multiplexer, together with an output data value. Pin inputs are captured through a synchronizer and can be read back.

Software changes output bits in two ways. It can write the output data register whole. It can also write a set/clear word that sets and clears any mix of bits in one bus write, so no read-modify-write is needed and an interrupt cannot fall between a read and a write. A key sequence on the lock register freezes the configuration of selected pins until the next reset. This protects safety-relevant pin settings from stray writes.

Word addresses: 0 mode, 1 drive type, 2 speed, 3 pull, 4 input data (read-only), 5 output data, 6 set/clear (write-only), 7 lock, 8 alternate-function select for pins 0–7, 9 alternate-function select for pins 8–15. Unmapped addresses read 0.

Top module: `gpx_port`

## Requirements
- R1: While reset is high and in the first cycle after it, every mode, drive type, speed, pull and alternate-function field is 0 (all pins floating inputs, no alternate function). The output data is 0, every pin output is inactive and the lock register reads 0.
- R2: Pin n's mode is bits 2n+1:2n of word 0, encoded 00 input, 01 output, 10 alternate function, 11 analog. Bit n of `pin_oe`, `pin_af_en` or `pin_analog` is 1 exactly when the pin holds 01, 10 or 11 respectively. The output follows in the cycle after the write.
- R3: Bit n of word 1 drives `pin_od[n]` (0 push-pull, 1 open-drain). Word 2 drives `pin_speed` bit for bit. Pin n's pull is bits 2n+1:2n of word 3: 01 raises `pin_pu[n]`, 10 raises `pin_pd[n]`, and 00 or 11 raises neither.
- R4: The 4-bit function select of pin n is in word 8 for n<8 and in word 9 for n≥8, at bits 4(n mod 8)+3:4(n mod 8). It appears on `pin_af_sel[4n+3:4n]`.
- R5: A write to word 6 sets output bit n where data bit n (15:0) is 1 and clears it where data bit n+16 is 1. When both are 1, set wins. Other bits keep their value, the new value is on `pin_out` the next cycle, and word 6 reads 0.
- R6: A write to word 5 loads its low 16 bits into the output data, visible on `pin_out` the next cycle. Word 5 reads back those bits with the upper half 0.
- R7: Word 7 holds the key at bit 16 and per-pin lock bits at 15:0. Three writes lock the port: key=1 with bits B, then key=0 with B, then key=1 with B, then one read of word 7. After that read, word 7 reads key=1 with B.
- R8: A write of the wrong key or bits, or a read of word 7 before the third write, abandons the sequence without locking (key reads 0). Configuration stays writable after such a failure.
- R9: When locked, the mode, speed, pull and function-select fields of every pin whose lock bit is 1 ignore writes until reset. Fields of other pins still take writes, and the lock bits and key no longer change.
- R10: When locked, lock bit i for i in 0–7 freezes drive-type bits i and i+8 together. Lock bits 8–15 leave the drive type writable.
- R11: Word 4 bits 15:0 show `pin_in` through a two-register synchronizer, so a change is readable after the second rising edge. A pin in analog mode reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (drives the lock sequence) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on address |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Output data value |
| pin_oe | output | 16 | Pin in output mode |
| pin_af_en | output | 16 | Pin in alternate-function mode |
| pin_analog | output | 16 | Pin in analog mode |
| pin_od | output | 16 | Open-drain drive |
| pin_pu | output | 16 | Pull-up enable |
| pin_pd | output | 16 | Pull-down enable |
| pin_speed | output | 32 | Two speed bits per pin |
| pin_af_sel | output | 64 | Four function-select bits per pin |

## Verification
A corrupted lock state shows on the next access. A lock that is lost lets a locked field change on the next configuration write. A lock taken by mistake makes an unlocked field ignore that write. Either way the error is visible on the pin outputs one cycle later and on the lock key readback at once. A wrong output-data update shows on `pin_out` in the cycle after the set/clear write. A synchronizer of the wrong depth moves the input readback by one edge, so the bench samples it before and after each of the two edges.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;
    localparam int unsigned NPIN   = 16;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned AF_W   = 4;

    localparam logic [ADDR_W-1:0] RA_MODE   = 4'd0;
    localparam logic [ADDR_W-1:0] RA_OTYPE  = 4'd1;
    localparam logic [ADDR_W-1:0] RA_SPEED  = 4'd2;
    localparam logic [ADDR_W-1:0] RA_PULL   = 4'd3;
    localparam logic [ADDR_W-1:0] RA_IN     = 4'd4;
    localparam logic [ADDR_W-1:0] RA_OUT    = 4'd5;
    localparam logic [ADDR_W-1:0] RA_SETCLR = 4'd6;
    localparam logic [ADDR_W-1:0] RA_LOCK   = 4'd7;
    localparam logic [ADDR_W-1:0] RA_AFLO   = 4'd8;
    localparam logic [ADDR_W-1:0] RA_AFHI   = 4'd9;

    typedef enum logic [1:0] {
        MD_IN  = 2'b00,
        MD_OUT = 2'b01,
        MD_ALT = 2'b10,
        MD_ANA = 2'b11
    } pin_mode_e;

    typedef enum logic [2:0] {
        LK_IDLE, LK_ARM1, LK_ARM2, LK_ARM3, LK_DONE
    } lock_state_e;

    typedef struct packed {
        logic [2*NPIN-1:0]    mode;
        logic [NPIN-1:0]      otype;
        logic [2*NPIN-1:0]    speed;
        logic [2*NPIN-1:0]    pull;
        logic [AF_W*NPIN-1:0] af;
    } port_cfg_t;

    function automatic logic [2*NPIN-1:0] spread2(input logic [NPIN-1:0] b);
        logic [2*NPIN-1:0] r;
        for (int i = 0; i < NPIN; i++) r[2*i +: 2] = {2{b[i]}};
        return r;
    endfunction

    function automatic logic [AF_W*NPIN-1:0] spread4(input logic [NPIN-1:0] b);
        logic [AF_W*NPIN-1:0] r;
        for (int i = 0; i < NPIN; i++) r[AF_W*i +: AF_W] = {AF_W{b[i]}};
        return r;
    endfunction
endpackage

// File: rtl/gpx_cfg_bank.sv
`timescale 1ns/1ps
module gpx_cfg_bank
    import gpx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NPIN-1:0]         freeze,
    input  logic [NPIN-1:0]         freeze_ot,
    output port_cfg_t               cfg
);
    localparam int unsigned HALF = AF_W * NPIN / 2;

    logic [2*NPIN-1:0]    m2;
    logic [AF_W*NPIN-1:0] m4;

    assign m2 = spread2(freeze);
    assign m4 = spread4(freeze);

    // A set mask bit keeps the stored bit; a clear one takes the new one.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                RA_MODE:  cfg.mode  <= (cfg.mode  & m2) | (wdata & ~m2);
                RA_OTYPE: cfg.otype <= (cfg.otype & freeze_ot) | (wdata[NPIN-1:0] & ~freeze_ot);
                RA_SPEED: cfg.speed <= (cfg.speed & m2) | (wdata & ~m2);
                RA_PULL:  cfg.pull  <= (cfg.pull  & m2) | (wdata & ~m2);
                RA_AFLO:  cfg.af[HALF-1:0] <= (cfg.af[HALF-1:0] & m4[HALF-1:0])
                                              | (wdata & ~m4[HALF-1:0]);
                RA_AFHI:  cfg.af[2*HALF-1:HALF] <= (cfg.af[2*HALF-1:HALF] & m4[2*HALF-1:HALF])
                                                   | (wdata & ~m4[2*HALF-1:HALF]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpx_lock_fsm.sv
`timescale 1ns/1ps
module gpx_lock_fsm
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPIN:0]     wkey,   // key at the top bit, pin bits below
    output logic              locked,
    output logic [NPIN-1:0]   bits
);
    lock_state_e st;
    logic hit, key, same;

    assign hit  = (addr == RA_LOCK);
    assign key  = wkey[NPIN];
    assign same = (wkey[NPIN-1:0] == bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LK_IDLE;
            bits <= '0;
        end else if (hit) begin
            case (st)
                LK_IDLE: if (we) begin
                    bits <= wkey[NPIN-1:0];
                    if (key) st <= LK_ARM1;
                end
                LK_ARM1: if (we) st <= (!key && same) ? LK_ARM2 : LK_IDLE;
                         else if (re) st <= LK_IDLE;
                LK_ARM2: if (we) st <= (key && same) ? LK_ARM3 : LK_IDLE;
                         else if (re) st <= LK_IDLE;
                LK_ARM3: if (we) st <= LK_IDLE;
                         else if (re) st <= LK_DONE;
                default: st <= LK_DONE;
            endcase
        end
    end

    assign locked = (st == LK_DONE);
endmodule

// File: rtl/gpx_data_path.sv
`timescale 1ns/1ps
module gpx_data_path
    import gpx_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPIN-1:0]   pin_in,
    input  logic [NPIN-1:0]   analog,
    output logic [NPIN-1:0]   odr,
    output logic [NPIN-1:0]   idr
);
    logic [NPIN-1:0] set_b, clr_b;
    logic [NPIN-1:0] sync_q [SYNC_DEPTH];

    assign set_b = wdata[NPIN-1:0];
    assign clr_b = wdata[DATA_W-1:NPIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            odr <= '0;
        end else if (we && addr == RA_OUT) begin
            odr <= wdata[NPIN-1:0];
        end else if (we && addr == RA_SETCLR) begin
            odr <= (odr & ~clr_b) | set_b;   // set takes priority
        end
    end

    generate
        for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q[s] <= '0;
                else     sync_q[s] <= (s == 0) ? pin_in : sync_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign idr = sync_q[SYNC_DEPTH-1] & ~analog;
endmodule

// File: rtl/gpx_port.sv
`timescale 1ns/1ps
module gpx_port
    import gpx_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic                    bus_re,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NPIN-1:0]         pin_in,
    output logic [NPIN-1:0]         pin_out,
    output logic [NPIN-1:0]         pin_oe,
    output logic [NPIN-1:0]         pin_af_en,
    output logic [NPIN-1:0]         pin_analog,
    output logic [NPIN-1:0]         pin_od,
    output logic [NPIN-1:0]         pin_pu,
    output logic [NPIN-1:0]         pin_pd,
    output logic [2*NPIN-1:0]       pin_speed,
    output logic [AF_W*NPIN-1:0]    pin_af_sel
);
    localparam int unsigned HALF = AF_W * NPIN / 2;
    localparam int unsigned OT_H = NPIN / 2;

    port_cfg_t         cfg_q;
    logic [2*NPIN-1:0] mode_q;
    logic              lk_locked;
    logic [NPIN-1:0]   lk_bits;
    logic [NPIN-1:0]   freeze, freeze_ot;
    logic [NPIN-1:0]   odr, idr;

    assign freeze    = lk_locked ? lk_bits : '0;
    // Lower lock bits cover both halves of the drive-type word.
    assign freeze_ot = lk_locked ? {lk_bits[OT_H-1:0], lk_bits[OT_H-1:0]} : '0;

    gpx_cfg_bank u_cfg (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .freeze(freeze), .freeze_ot(freeze_ot), .cfg(cfg_q)
    );

    gpx_lock_fsm u_lock (
        .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
        .wkey(bus_wdata[NPIN:0]), .locked(lk_locked), .bits(lk_bits)
    );

    gpx_data_path #(.SYNC_DEPTH(SYNC_DEPTH)) u_data (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .pin_in(pin_in), .analog(pin_analog), .odr(odr), .idr(idr)
    );

    assign mode_q = cfg_q.mode;

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            assign pin_oe[i]     = (mode_q[2*i +: 2] == MD_OUT);
            assign pin_af_en[i]  = (mode_q[2*i +: 2] == MD_ALT);
            assign pin_analog[i] = (mode_q[2*i +: 2] == MD_ANA);
            assign pin_pu[i]     = (cfg_q.pull[2*i +: 2] == 2'b01);
            assign pin_pd[i]     = (cfg_q.pull[2*i +: 2] == 2'b10);
        end
    endgenerate

    assign pin_out    = odr;
    assign pin_od     = cfg_q.otype;
    assign pin_speed  = cfg_q.speed;
    assign pin_af_sel = cfg_q.af;

    always_comb begin
        case (bus_addr)
            RA_MODE:  bus_rdata = cfg_q.mode;
            RA_OTYPE: bus_rdata = {{(DATA_W-NPIN){1'b0}}, cfg_q.otype};
            RA_SPEED: bus_rdata = cfg_q.speed;
            RA_PULL:  bus_rdata = cfg_q.pull;
            RA_IN:    bus_rdata = {{(DATA_W-NPIN){1'b0}}, idr};
            RA_OUT:   bus_rdata = {{(DATA_W-NPIN){1'b0}}, odr};
            RA_LOCK:  bus_rdata = {{(DATA_W-NPIN-1){1'b0}}, lk_locked, lk_bits};
            RA_AFLO:  bus_rdata = cfg_q.af[HALF-1:0];
            RA_AFHI:  bus_rdata = cfg_q.af[2*HALF-1:HALF];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpx_port_chk.sv
`timescale 1ns/1ps
module gpx_port_chk
    import gpx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NPIN-1:0]     pin_out,
    input logic [NPIN-1:0]     pin_od,
    input logic [NPIN-1:0]     pin_analog,
    input logic [2*NPIN-1:0]   mode_q,
    input logic                locked,
    input logic [NPIN-1:0]     lck_bits
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0 && pin_od == '0 && mode_q == '0 && !locked));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RA_SETCLR) |=>
        pin_out == (($past(pin_out) & ~$past(bus_wdata[DATA_W-1:NPIN])) | $past(bus_wdata[NPIN-1:0])));

    a_r6_out_load: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RA_OUT) |=> pin_out == $past(bus_wdata[NPIN-1:0]));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(lck_bits)));

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> ((mode_q ^ $past(mode_q)) & spread2(lck_bits)) == '0);

    a_r10_otype_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> ((pin_od ^ $past(pin_od)) & {lck_bits[NPIN/2-1:0], lck_bits[NPIN/2-1:0]}) == '0);

    a_r11_analog_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RA_IN) |-> ((bus_rdata[NPIN-1:0] & pin_analog) == '0
                                 && bus_rdata[DATA_W-1:NPIN] == '0));
endmodule

bind gpx_port gpx_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_od(pin_od), .pin_analog(pin_analog), .mode_q(mode_q),
    .locked(lk_locked), .lck_bits(lk_bits)
);

// File: tb/gpx_port_bench.sv
`timescale 1ns/1ps
module gpx_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_af_en, pin_analog, pin_od, pin_pu, pin_pd;
    logic [31:0] pin_speed;
    logic [63:0] pin_af_sel;

    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    gpx_port u_gpx_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_af_en(pin_af_en),
        .pin_analog(pin_analog), .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd),
        .pin_speed(pin_speed), .pin_af_sel(pin_af_sel)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] dup2(input logic [15:0] b);
        logic [31:0] r;
        for (int i = 0; i < 16; i++) r[2*i +: 2] = {2{b[i]}};
        return r;
    endfunction

    function automatic logic [63:0] dup4(input logic [15:0] b);
        logic [63:0] r;
        for (int i = 0; i < 16; i++) r[4*i +: 4] = {4{b[i]}};
        return r;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before the sequence finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] exp_o;
        logic [15:0] b;
        @(negedge clk);
        do_reset();

        // R1 reset values
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], d);
            chk($sformatf("R1 word %0d after reset", a), {32'h0, d}, 64'h0);
        end
        chk("R1 pin outputs after reset",
            {pin_out, pin_oe, pin_af_en, pin_od}, 64'h0);

        // R2 mode sweep
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 4; m++) begin
                wr(4'd0, 32'(m) << (2*p));
                chk($sformatf("R2 pin %0d mode %0d", p, m),
                    {16'h0, pin_oe, pin_af_en, pin_analog},
                    {16'h0, 16'(m == 1) << p, 16'(m == 2) << p, 16'(m == 3) << p});
            end
        end
        rd(4'd0, d);
        chk("R2 mode readback", {32'h0, d}, {32'h0, 32'h3 << 30});
        wr(4'd0, 32'h0);

        // R3 drive type, pull, speed
        for (int p = 0; p < 16; p++) begin
            wr(4'd1, 32'h1 << p);
            chk($sformatf("R3 drive type pin %0d", p), {48'h0, pin_od}, {48'h0, 16'h1 << p});
            for (int v = 0; v < 4; v++) begin
                wr(4'd3, 32'(v) << (2*p));
                chk($sformatf("R3 pull pin %0d code %0d", p, v), {32'h0, pin_pu, pin_pd},
                    {32'h0, 16'(v == 1) << p, 16'(v == 2) << p});
            end
        end
        wr(4'd1, 32'h0); wr(4'd3, 32'h0);
        for (int k = 0; k < 4; k++) begin
            d = 32'h9E37_79B9 * (k + 1);
            wr(4'd2, d);
            chk($sformatf("R3 speed pattern %0d", k), {32'h0, pin_speed}, {32'h0, d});
        end
        wr(4'd2, 32'h0);

        // R4 function select placement
        for (int p = 0; p < 16; p++) begin
            logic [3:0] v;
            v = 4'((p * 5 + 3) & 15);
            wr((p < 8) ? 4'd8 : 4'd9, 32'(v) << (4 * (p % 8)));
            chk($sformatf("R4 function select pin %0d", p), pin_af_sel, 64'(v) << (4*p));
            wr((p < 8) ? 4'd8 : 4'd9, 32'h0);
        end

        // R6 direct output load
        wr(4'd5, 32'hDEAD_A5A5);
        chk("R6 output load", {48'h0, pin_out}, {48'h0, 16'hA5A5});
        rd(4'd5, d);
        chk("R6 output readback", {32'h0, d}, {32'h0, 32'h0000_A5A5});

        // R5 set/clear sweep, set wins on overlap
        exp_o = 16'hA5A5;
        for (int k = 0; k < 20; k++) begin
            logic [15:0] s, c;
            s = 16'(k * 16'h1357);
            c = 16'(k * 16'h2461) ^ 16'hF0F0;
            if (k == 18) begin s = 16'hFFFF; c = 16'hFFFF; end
            if (k == 19) begin s = 16'h0000; c = 16'hFFFF; end
            wr(4'd6, {c, s});
            exp_o = (exp_o & ~c) | s;
            chk($sformatf("R5 set/clear step %0d", k), {48'h0, pin_out}, {48'h0, exp_o});
        end
        rd(4'd6, d);
        chk("R5 set/clear word reads zero", {32'h0, d}, 64'h0);

        // R11 synchronizer latency
        for (int k = 0; k < 4; k++) begin
            logic [15:0] prev, nxt;
            prev = pin_in;
            nxt = 16'(16'hC3A5 * (k + 3));
            pin_in = nxt;
            bus_addr = 4'd4;
            #1 chk($sformatf("R11 input before edges %0d", k), {48'h0, bus_rdata[15:0]}, {48'h0, prev});
            @(negedge clk);
            #1 chk($sformatf("R11 input after one edge %0d", k), {48'h0, bus_rdata[15:0]}, {48'h0, prev});
            @(negedge clk);
            #1 chk($sformatf("R11 input after two edges %0d", k), {32'h0, bus_rdata}, {48'h0, nxt});
            @(negedge clk);
        end
        wr(4'd0, 32'hC000_0003);
        pin_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        rd(4'd4, d);
        chk("R11 analog pins read zero", {32'h0, d}, {32'h0, 32'h0000_7FFE});
        wr(4'd0, 32'h0);

        // R8 broken sequences
        wr(4'd7, 32'h0001_0180); wr(4'd7, 32'h0000_0181); wr(4'd7, 32'h0001_0180); rd(4'd7, d);
        rd(4'd7, d);
        chk("R8 wrong bits in step two", {32'h0, d[16]}, 64'h0);
        wr(4'd7, 32'h0001_0180); wr(4'd7, 32'h0000_0180); wr(4'd7, 32'h0000_0180); rd(4'd7, d);
        rd(4'd7, d);
        chk("R8 wrong key in step three", {32'h0, d[16]}, 64'h0);
        wr(4'd7, 32'h0001_0180); rd(4'd7, d); wr(4'd7, 32'h0000_0180); wr(4'd7, 32'h0001_0180);
        rd(4'd7, d); rd(4'd7, d);
        chk("R8 early read", {32'h0, d[16]}, 64'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d);
        chk("R8 still writable", {32'h0, d}, {32'h0, 32'hFFFF_FFFF});
        wr(4'd0, 32'h0);

        // R7 good sequence
        b = 16'h0180;
        wr(4'd7, {15'h0, 1'b1, b}); wr(4'd7, {15'h0, 1'b0, b}); wr(4'd7, {15'h0, 1'b1, b});
        rd(4'd7, d);
        rd(4'd7, d);
        chk("R7 key set after sequence", {32'h0, d}, {32'h0, 15'h0, 1'b1, b});

        // R9 locked pins frozen, others writable
        wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, d);
        chk("R9 mode write under lock", {32'h0, d}, {32'h0, ~dup2(b)});
        wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, d);
        chk("R9 speed write under lock", {32'h0, d}, {32'h0, ~dup2(b)});
        wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, d);
        chk("R9 pull write under lock", {32'h0, d}, {32'h0, ~dup2(b)});
        wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
        chk("R9 function select under lock", pin_af_sel, ~dup4(b));
        wr(4'd7, 32'h0001_FFFF); wr(4'd7, 32'h0000_0000); rd(4'd7, d);
        chk("R9 lock word frozen", {32'h0, d}, {32'h0, 15'h0, 1'b1, b});

        // R10 drive type lock pairs
        wr(4'd1, 32'h0000_FFFF);
        chk("R10 drive type under lock", {48'h0, pin_od},
            {48'h0, ~{b[7:0], b[7:0]}});

        // back to reset: lock released
        do_reset();
        rd(4'd7, d);
        chk("R1 lock cleared by reset", {32'h0, d}, 64'h0);
        wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, d);
        chk("R1 mode writable after reset", {32'h0, d}, {32'h0, 32'hFFFF_FFFF});

        summary();
        $finish;
    end
endmodule